// File: doc/BRIEF.md
# Compressed Trie Child Address Calculator

This block takes one node word of a multi-pattern matching trie, plus the input byte being scanned, and computes which node the scan moves to next. The node word holds a 256-bit child-presence map, a base pointer to the first child, a failure pointer and a rules pointer. Children are stored packed one after another in node-sized memory lines, so only children that exist take up space.

If the map bit selected by the byte is set, the block counts the set map bits below that position. It scales that count by the node size and adds it to the base pointer. The sum clamps at the largest pointer value rather than wrapping. If the bit is clear, the result is the failure pointer.

A valid strobe travels with each request. One request is accepted per clock, and the result appears two clock edges later. The rules pointer is carried alongside the result unchanged.

Top module: `trie_next_node`

## Requirements
- R1: After synchronous reset, out_valid, out_hit and out_addr are all zero.
- R2: A request presented with in_valid high at one rising edge produces out_valid high after the second following rising edge. out_valid is low in cycles that have no matching request.
- R3: The tested map bit is in_map[in_key]. Key bits 7:5 select the 32-bit lane in_map[32*lane +: 32], and key bits 4:0 select the bit inside that lane.
- R4: When the tested bit is 0, out_hit is 0 and out_addr equals in_fail.
- R5: When the tested bit is 1, out_hit is 1 and out_addr equals in_base + 64 * N. N is the number of set map bits at indices below in_key: the full counts of all lower lanes plus the set bits below the position inside the selected lane.
- R6: When in_base + 64 * N exceeds 24'hFFFFFF, out_addr is 24'hFFFFFF.
- R7: out_rules equals the in_rules of the same request.
- R8: Requests on consecutive clocks are processed independently, with no interaction between them.
- R9: out_hit is 0 whenever out_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe |
| in_map | input | 256 | Child-presence map of the current node |
| in_base | input | 24 | Address of the first child |
| in_fail | input | 24 | Failure pointer |
| in_rules | input | 24 | Rules pointer |
| in_key | input | 8 | Current input byte |
| out_valid | output | 1 | Result strobe |
| out_hit | output | 1 | Child present for the byte |
| out_addr | output | 24 | Next node address |
| out_rules | output | 24 | Rules pointer of the request |

## Verification
A hit and saturation can occur in the same cycle, which is when the clamp has to take effect. The bench provokes this with a base pointer near the top of the address space and a dense map with a high key, so that the scaled count pushes the sum past the limit. The same base pointer combined with a missed byte checks that the failure path never clamps. Each result is compared with a sum that the bench computes bit by bit, so the clamp, the lane split and the failure path are all judged against one independent model.

// File: rtl/trie_nn_pkg.sv
package trie_nn_pkg;

    localparam int MAP_BITS   = 256;
    localparam int PTR_W      = 24;
    localparam int LANE_W     = 32;
    localparam int LANES      = MAP_BITS / LANE_W;
    localparam int KEY_W      = $clog2(MAP_BITS);
    localparam int POS_W      = $clog2(LANE_W);
    localparam int SEL_W      = KEY_W - POS_W;
    localparam int CNT_W      = $clog2(LANE_W + 1);
    localparam int PFX_W      = $clog2(MAP_BITS + 1);
    localparam int NODE_BYTES = 64;
    localparam int NODE_SH    = $clog2(NODE_BYTES);
    localparam int ADD_W      = PTR_W + 1;
    localparam logic [PTR_W-1:0] PTR_MAX = {PTR_W{1'b1}};

    typedef logic [CNT_W-1:0] lane_cnt_t;

    typedef struct packed {
        logic                        valid;
        logic                        hit;
        logic [SEL_W-1:0]            lane;
        lane_cnt_t                   part;
        logic [LANES-1:0][CNT_W-1:0] lane_cnt;
        logic [PTR_W-1:0]            base_ptr;
        logic [PTR_W-1:0]            fail_ptr;
        logic [PTR_W-1:0]            rule_ptr;
    } stage1_t;

    function automatic lane_cnt_t count_ones(input logic [LANE_W-1:0] v);
        lane_cnt_t acc;
        acc = '0;
        for (int i = 0; i < LANE_W; i++) begin
            acc = acc + lane_cnt_t'(v[i]);
        end
        return acc;
    endfunction

    function automatic logic [PTR_W-1:0] clamp_add(input logic [PTR_W-1:0] a,
                                                    input logic [PFX_W-1:0] n);
        logic [ADD_W-1:0] wide;
        wide = {1'b0, a} + ADD_W'({n, {NODE_SH{1'b0}}});
        return wide[ADD_W-1] ? PTR_MAX : wide[PTR_W-1:0];
    endfunction

endpackage

// File: rtl/trie_lane_counter.sv
module trie_lane_counter
    import trie_nn_pkg::*;
(
    input  logic [MAP_BITS-1:0]       map_i,
    output logic [LANES-1:0][CNT_W-1:0] cnt_o
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign cnt_o[g] = count_ones(map_i[g*LANE_W +: LANE_W]);
    end
endmodule

// File: rtl/trie_bit_probe.sv
module trie_bit_probe
    import trie_nn_pkg::*;
(
    input  logic [MAP_BITS-1:0] map_i,
    input  logic [KEY_W-1:0]    key_i,
    output logic                hit_o,
    output logic [SEL_W-1:0]    lane_o,
    output lane_cnt_t           part_o
);
    logic [POS_W-1:0]  pos;
    logic [LANE_W-1:0] word;
    logic [LANE_W-1:0] below;

    always_comb begin
        lane_o = key_i[KEY_W-1:POS_W];
        pos    = key_i[POS_W-1:0];
        word   = map_i[lane_o*LANE_W +: LANE_W];
        below  = (LANE_W'(1) << pos) - LANE_W'(1);
        hit_o  = word[pos];
        part_o = count_ones(word & below);
    end
endmodule

// File: rtl/trie_next_addr.sv
module trie_next_addr
    import trie_nn_pkg::*;
(
    input  stage1_t           s_i,
    output logic [PTR_W-1:0]  addr_o
);
    logic [PFX_W-1:0] prefix;

    always_comb begin
        prefix = PFX_W'(s_i.part);
        for (int r = 0; r < LANES; r++) begin
            if (SEL_W'(r) < s_i.lane) begin
                prefix = prefix + PFX_W'(s_i.lane_cnt[r]);
            end
        end
        addr_o = s_i.hit ? clamp_add(s_i.base_ptr, prefix) : s_i.fail_ptr;
    end
endmodule

// File: rtl/trie_next_node.sv
module trie_next_node
    import trie_nn_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    input  logic [MAP_BITS-1:0]  in_map,
    input  logic [PTR_W-1:0]     in_base,
    input  logic [PTR_W-1:0]     in_fail,
    input  logic [PTR_W-1:0]     in_rules,
    input  logic [KEY_W-1:0]     in_key,
    output logic                 out_valid,
    output logic                 out_hit,
    output logic [PTR_W-1:0]     out_addr,
    output logic [PTR_W-1:0]     out_rules
);
    stage1_t                     s1_d, s1_q;
    logic [LANES-1:0][CNT_W-1:0] lane_cnt;
    logic                        probe_hit;
    logic [SEL_W-1:0]            probe_lane;
    lane_cnt_t                   probe_part;
    logic [PTR_W-1:0]            next_addr;

    trie_lane_counter u_cnt (
        .map_i (in_map),
        .cnt_o (lane_cnt)
    );

    trie_bit_probe u_probe (
        .map_i  (in_map),
        .key_i  (in_key),
        .hit_o  (probe_hit),
        .lane_o (probe_lane),
        .part_o (probe_part)
    );

    always_comb begin
        s1_d.valid    = in_valid;
        s1_d.hit      = probe_hit;
        s1_d.lane     = probe_lane;
        s1_d.part     = probe_part;
        s1_d.lane_cnt = lane_cnt;
        s1_d.base_ptr = in_base;
        s1_d.fail_ptr = in_fail;
        s1_d.rule_ptr = in_rules;
    end

    always_ff @(posedge clk) begin
        if (rst) s1_q <= '0;
        else     s1_q <= s1_d;
    end

    trie_next_addr u_addr (
        .s_i    (s1_q),
        .addr_o (next_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_hit   <= 1'b0;
            out_addr  <= '0;
            out_rules <= '0;
        end else begin
            out_valid <= s1_q.valid;
            out_hit   <= s1_q.valid & s1_q.hit;
            out_addr  <= next_addr;
            out_rules <= s1_q.rule_ptr;
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        s1_q.valid |=> out_valid);

    // R2
    no_ghost_chk: assert property (@(posedge clk) disable iff (rst)
        !s1_q.valid |=> !out_valid);

    // R4
    miss_fail_chk: assert property (@(posedge clk) disable iff (rst)
        (s1_q.valid && !s1_q.hit) |=> (out_addr == $past(s1_q.fail_ptr)));

    // R6
    no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_hit) |-> (out_addr >= $past(s1_q.base_ptr)));

    // R7
    rules_pass_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_rules == $past(s1_q.rule_ptr)));

    // R9
    hit_gated_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> !out_hit);
endmodule

// File: tb/test_trie_next_node.sv
module test_trie_next_node;
    import trie_nn_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic                clk = 1'b0;
    logic                rst;
    logic                in_valid;
    logic [MAP_BITS-1:0] in_map;
    logic [PTR_W-1:0]    in_base, in_fail, in_rules;
    logic [KEY_W-1:0]    in_key;
    logic                out_valid, out_hit;
    logic [PTR_W-1:0]    out_addr, out_rules;

    int total = 0;
    int bad   = 0;

    typedef struct {
        logic             v;
        logic             hit;
        logic             sat;
        logic [PTR_W-1:0] addr;
        logic [PTR_W-1:0] rules;
    } exp_t;

    exp_t pipe0, pipe1;

    always #(CLK_PERIOD/2) clk = ~clk;

    trie_next_node i_trie_next_node (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_map(in_map),
        .in_base(in_base), .in_fail(in_fail), .in_rules(in_rules), .in_key(in_key),
        .out_valid(out_valid), .out_hit(out_hit), .out_addr(out_addr), .out_rules(out_rules)
    );

    // Reference model: R3 bit pick, R5 bit-by-bit count, R6 clamp, R4 failure
    function automatic exp_t model(input logic v, input logic [MAP_BITS-1:0] m,
                                   input logic [PTR_W-1:0] b, input logic [PTR_W-1:0] f,
                                   input logic [PTR_W-1:0] r, input logic [KEY_W-1:0] k);
        exp_t e;
        longint n;
        longint s;
        n = 0;
        for (int i = 0; i < int'(k); i++) n += longint'(m[i]);
        s = longint'(b) + n * 64;
        e.v     = v;
        e.hit   = v & m[k];
        e.sat   = m[k] && (s > 64'hFFFFFF);
        e.addr  = m[k] ? (e.sat ? 24'hFFFFFF : s[23:0]) : f;
        e.rules = r;
        return e;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic judge();
        check("R2", 32'(out_valid), 32'(pipe1.v));
        if (pipe1.v) begin
            check(pipe1.hit ? "R5" : "R4", 32'(out_hit), 32'(pipe1.hit));
            check(pipe1.sat ? "R6" : (pipe1.hit ? "R5" : "R4"), 32'(out_addr), 32'(pipe1.addr));
            check("R7", 32'(out_rules), 32'(pipe1.rules));
        end else begin
            check("R9", 32'(out_hit), 32'd0);
        end
    endtask

    // R8: one request per negedge, results judged two cycles later
    task automatic step(input logic v, input logic [MAP_BITS-1:0] m, input logic [PTR_W-1:0] b,
                        input logic [PTR_W-1:0] f, input logic [PTR_W-1:0] r,
                        input logic [KEY_W-1:0] k);
        @(negedge clk);
        judge();
        pipe1 = pipe0;
        pipe0 = model(v, m, b, f, r, k);
        in_valid = v; in_map = m; in_base = b; in_fail = f; in_rules = r; in_key = k;
    endtask

    function automatic logic [MAP_BITS-1:0] rand_map();
        logic [MAP_BITS-1:0] m;
        for (int i = 0; i < LANES; i++) m[i*32 +: 32] = $urandom();
        return m;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        pipe0 = '{default: '0};
        pipe1 = '{default: '0};
        rst = 1'b1; in_valid = 1'b0; in_map = '0; in_base = '0;
        in_fail = '0; in_rules = '0; in_key = '0;
        repeat (3) @(negedge clk);
        // R1
        check("R1", 32'(out_valid), 32'd0);
        check("R1", 32'(out_hit), 32'd0);
        check("R1", 32'(out_addr), 32'd0);
        rst = 1'b0;

        // R4: empty map
        step(1'b1, '0, 24'h001000, 24'h00ABCD, 24'h000011, 8'd77);
        // R5: key 0 hit, no bits below
        step(1'b1, 256'h1, 24'h002000, 24'h000001, 24'h000022, 8'd0);
        // R3/R5: lane 0 full, key 32 set -> N=32
        step(1'b1, {223'd0, 1'b1, 32'hFFFFFFFF}, 24'h010000, 24'h0, 24'h33, 8'd32);
        // R5: full map, key 255 -> N=255
        step(1'b1, {MAP_BITS{1'b1}}, 24'h000040, 24'h0, 24'h44, 8'd255);
        // R6: hit and clamp together
        step(1'b1, {MAP_BITS{1'b1}}, 24'hFFF000, 24'h123456, 24'h55, 8'd200);
        // R4: miss with high base never clamps
        step(1'b1, {MAP_BITS{1'b1}} ^ (256'h1 << 200), 24'hFFF000, 24'h123456, 24'h66, 8'd200);
        // R6: exact top without overflow: base FFFFC0 + 64*0
        step(1'b1, 256'h1, 24'hFFFFC0, 24'h0, 24'h77, 8'd0);
        // R9/R2: gap cycle with a hitting map
        step(1'b0, {MAP_BITS{1'b1}}, 24'h0, 24'h0, 24'h0, 8'd5);
        // R3: bit 31 vs bit 32 boundary
        step(1'b1, 256'h1 << 31, 24'h000100, 24'h0000AA, 24'h88, 8'd31);
        step(1'b1, 256'h1 << 31, 24'h000100, 24'h0000AA, 24'h99, 8'd32);

        for (int t = 0; t < 400; t++) begin
            logic [PTR_W-1:0] b;
            b = ($urandom_range(0, 3) == 0) ? (24'hFF0000 | 24'($urandom_range(0, 65535)))
                                            : 24'($urandom());
            step(($urandom_range(0, 5) != 0), rand_map(), b, 24'($urandom()),
                 24'($urandom()), 8'($urandom()));
        end
        step(1'b0, '0, '0, '0, '0, '0);
        step(1'b0, '0, '0, '0, '0, '0);
        step(1'b0, '0, '0, '0, '0, '0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule